// File: doc/BRIEF.md
# Peripheral Chip Select Decoder

This block watches bus cycles on a multiplexed address/data bus and turns I/O accesses into active-low peripheral chip selects. A base address, aligned to 2 KB, is loaded through a small configuration port. Above that base sit eight 256-byte slots. Six of them (indices 0, 1, 2, 3, 5 and 6) each own a select line. Slots 4 and 7 have no line. The select follows the address phase strobe in the same cycle, with no register delay. It is then held from a latched copy until the bus master signals the end of the cycle.

The selects fall into two timing groups. Indices 5 and 6 always stretch the access to at least 150 ns. Indices 0 to 3 stretch it to at least 800 ns, but only when the extended-wait bit in the configuration is set. While the stretch runs, a ready output is pulled low. The stretch lengths are converted to clock counts from the clock period parameter, rounding up. During a bus-hold condition the select outputs are forced high and flagged for floating, and new address phases are not taken.

Top module: `pcs_decoder`

## Requirements
- R1: After reset every `pcs_n` bit is 1, `ready` is 1, `pcs_float` is 0, and no address selects anything until the first configuration write.
- R2: With base B, an I/O address phase at address A drives `pcs_n[n]` low and all other bits high when A[19:11] equals B[19:11] and n = A[10:8] is one of 0, 1, 2, 3, 5 or 6.
- R3: When A[10:8] is 4 or 7, or A lies outside the 2 KB window, no select is driven. `pcs_n[4]` is always 1.
- R4: A configuration write stores only bits 19:11 of `cfg_base`. Bits 10:0 have no effect on decoding.
- R5: An address phase with `io_cycle` = 0 drives no select and leaves `ready` high.
- R6: The select goes low in the cycle where `ale` is high. It stays low through the cycle where `cyc_end` is high, and is released in the following cycle.
- R7: A hit on index 5 or 6 holds `ready` low for ceil(SHORT_NS/CLK_NS) cycles, starting with the `ale` cycle. With the defaults this is 8 cycles.
- R8: A hit on indices 0 to 3 holds `ready` low for ceil(LONG_NS/CLK_NS) cycles (40 with the defaults) when the extended-wait bit is 1. When that bit is 0, `ready` stays high.
- R9: While `hold` is 1, `pcs_n` is all ones and `pcs_float` is 1. An `ale` pulse during hold is ignored. A select that was active before the hold reappears once the hold drops, provided the cycle has not ended.
- R10: When `ale` and `cyc_end` are high in the same cycle, the new address phase wins. The old select is released in that cycle, the new one is shown, and the wait count restarts for the new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_base | input | ADDR_W | Base address; bits below 11 are dropped |
| cfg_ext_wait | input | 1 | Enables the long wait for indices 0 to 3 |
| ale | input | 1 | Address phase strobe |
| io_cycle | input | 1 | 1 when the current bus cycle is an I/O access |
| cyc_end | input | 1 | Marks the last cycle of the bus access |
| hold | input | 1 | Bus-hold condition |
| ad | input | ADDR_W | Multiplexed address/data bus |
| pcs_n | output | 7 | Active-low selects, bit n for index n, bit 4 unused (high) |
| pcs_float | output | 1 | 1 when select pads should float |
| ready | output | 1 | 0 while an access is being stretched |

## Verification
Two functions can land in the same cycle: the end of one access and the address phase of the next. The bench raises `cyc_end` together with a fresh `ale` that addresses a different index. In that same cycle it expects only the new select low and `ready` already low. It then counts the full wait for the new index, which shows whether the counter was reloaded rather than cleared. A second overlap places `ale` inside a hold window. The bench judges it by checking that the earlier select returns unchanged after the hold ends.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int NUM_SEL  = 7;
  localparam int REGION_W = 8;
  localparam int IDX_W    = 3;
  localparam int ALIGN_W  = REGION_W + IDX_W;
  // index 4 and 7 have no line
  localparam logic [NUM_SEL-1:0] SEL_PRESENT = 7'b110_1111;
  // indices using the long (optional) stretch
  localparam logic [NUM_SEL-1:0] GRP_LONG    = 7'b000_1111;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/pcs_base_reg.sv
module pcs_base_reg
  import pcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  localparam int HI_W  = ADDR_W - ALIGN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_ext_wait,
  output logic [HI_W-1:0]   base_hi,
  output logic              dec_en,
  output logic              ext_wait
);
  logic [HI_W-1:0] base_q, base_d;
  logic            en_q, en_d;
  logic            ext_q, ext_d;
  logic            lo_unused;

  assign lo_unused = ^cfg_base[ALIGN_W-1:0];

  always_comb begin
    base_d = base_q;
    en_d   = en_q;
    ext_d  = ext_q;
    if (cfg_we) begin
      base_d = cfg_base[ADDR_W-1:ALIGN_W];
      en_d   = 1'b1;
      ext_d  = cfg_ext_wait;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      en_q   <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      en_q   <= en_d;
      ext_q  <= ext_d;
    end
  end

  assign base_hi  = base_q;
  assign dec_en   = en_q;
  assign ext_wait = ext_q;

  a_r4_base_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(base_hi) && $stable(ext_wait));
  a_r1_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> dec_en);
endmodule

// File: rtl/pcs_region_decode.sv
module pcs_region_decode
  import pcs_pkg::*;
#(
  parameter int ADDR_W = 20,
  localparam int HI_W  = ADDR_W - ALIGN_W
) (
  input  logic [ADDR_W-1:0]  ad,
  input  logic [HI_W-1:0]    base_hi,
  input  logic               dec_en,
  input  logic               io_cycle,
  output logic [NUM_SEL-1:0] hit_vec
);
  logic             win_hit;
  logic [IDX_W-1:0] slot;
  logic             off_unused;

  assign off_unused = ^ad[REGION_W-1:0];
  assign win_hit    = dec_en && io_cycle && (ad[ADDR_W-1:ALIGN_W] == base_hi);
  assign slot       = ad[ALIGN_W-1:REGION_W];

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_slot
    if (SEL_PRESENT[i]) begin : g_on
      assign hit_vec[i] = win_hit && (slot == IDX_W'(i));
    end else begin : g_off
      assign hit_vec[i] = 1'b0;
    end
  end

  always_comb begin
    a_r2_one_hit: assert ($onehot0(hit_vec));
  end
endmodule

// File: rtl/pcs_wait_timer.sv
module pcs_wait_timer #(
  parameter int LONG_CYC  = 40,
  parameter int SHORT_CYC = 8,
  localparam int MAXC     = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC,
  localparam int CNT_W    = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_long,
  input  logic clr,
  output logic busy
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] long_init, short_init;

  assign long_init  = (LONG_CYC  > 0) ? CNT_W'(LONG_CYC - 1)  : '0;
  assign short_init = (SHORT_CYC > 0) ? CNT_W'(SHORT_CYC - 1) : '0;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_long ? long_init : short_init;
    else if (clr)           cnt_d = '0;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  a_r7_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load && !clr) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !load) |=> !busy);
endmodule

// File: rtl/pcs_decoder.sv
module pcs_decoder
  import pcs_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int CLK_NS   = 20,
  parameter int LONG_NS  = 800,
  parameter int SHORT_NS = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_ext_wait,
  input  logic              ale,
  input  logic              io_cycle,
  input  logic              cyc_end,
  input  logic              hold,
  input  logic [ADDR_W-1:0] ad,
  output logic [6:0]        pcs_n,
  output logic              pcs_float,
  output logic              ready
);
  localparam int HI_W      = ADDR_W - ALIGN_W;
  localparam int LONG_CYC  = int'(ceil_div(LONG_NS, CLK_NS));
  localparam int SHORT_CYC = int'(ceil_div(SHORT_NS, CLK_NS));

  logic [HI_W-1:0]    base_hi;
  logic               dec_en, ext_wait;
  logic [NUM_SEL-1:0] hit_vec, act_q, act_d, sel_now;
  logic               phase, need_wait, need_long, t_load, t_clr, t_busy;

  pcs_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .cfg_ext_wait(cfg_ext_wait), .base_hi(base_hi), .dec_en(dec_en),
    .ext_wait(ext_wait)
  );

  pcs_region_decode #(.ADDR_W(ADDR_W)) u_dec (
    .ad(ad), .base_hi(base_hi), .dec_en(dec_en), .io_cycle(io_cycle),
    .hit_vec(hit_vec)
  );

  // address phase accepted only outside hold
  assign phase     = ale && !hold;
  assign need_long = |(hit_vec & GRP_LONG) && ext_wait;
  assign need_wait = need_long || |(hit_vec & ~GRP_LONG);
  assign t_load    = phase && need_wait;
  assign t_clr     = phase || cyc_end;

  pcs_wait_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_long(need_long),
    .clr(t_clr), .busy(t_busy)
  );

  always_comb begin
    act_d = act_q;
    if (phase)        act_d = hit_vec;
    else if (cyc_end) act_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assign sel_now   = phase ? hit_vec : act_q;
  assign pcs_n     = hold ? '1 : ~sel_now;
  assign pcs_float = hold;
  assign ready     = !(t_load || t_busy);

  a_r3_idx4_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pcs_n[4]);
  a_r2_single_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~pcs_n));
  a_r6_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !cyc_end && !hold && (pcs_n != '1)) |=> (hold || ale || $stable(pcs_n)));
  a_r7_wait_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !hold) |-> (pcs_n != '1));
  a_r9_hold_float: assert property (@(posedge clk) disable iff (!rst_n)
    pcs_float |-> (pcs_n == '1));
endmodule

// File: tb/tb_pcs_decoder.sv
module tb_pcs_decoder;
  localparam int CLK      = 20;
  localparam int AW       = 20;
  localparam int LONG_NS  = 800;
  localparam int SHORT_NS = 150;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_ext_wait = 0, ale = 0, io_cycle = 0, cyc_end = 0, hold = 0;
  logic [AW-1:0] cfg_base = '0, ad = '0;
  logic [6:0] pcs_n;
  logic pcs_float, ready;

  int total = 0, bad = 0;
  logic [AW-1:0] m_base;
  bit m_en = 0, m_ext = 0;

  always #(CLK/2) clk = ~clk;

  pcs_decoder #(.ADDR_W(AW), .CLK_NS(CLK), .LONG_NS(LONG_NS), .SHORT_NS(SHORT_NS)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .cfg_ext_wait(cfg_ext_wait), .ale(ale), .io_cycle(io_cycle),
    .cyc_end(cyc_end), .hold(hold), .ad(ad), .pcs_n(pcs_n),
    .pcs_float(pcs_float), .ready(ready)
  );

  function automatic int cdiv(int a, int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int exp_idx(logic [AW-1:0] a, bit io);
    int n;
    if (!m_en || !io) return -1;
    if (a[AW-1:11] != m_base[AW-1:11]) return -1;
    n = int'(a[10:8]);
    if (n == 4 || n == 7) return -1;
    return n;
  endfunction

  function automatic logic [6:0] exp_pcs(int idx);
    if (idx < 0) return 7'h7F;
    return ~(7'b1 << idx);
  endfunction

  function automatic int exp_wait(int idx);
    if (idx < 0) return 0;
    if (idx >= 5) return cdiv(SHORT_NS, CLK);
    return m_ext ? cdiv(LONG_NS, CLK) : 0;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic write_cfg(logic [AW-1:0] b, bit ext);
    @(negedge clk);
    cfg_we = 1; cfg_base = b; cfg_ext_wait = ext;
    @(negedge clk);
    cfg_we = 0;
    m_base = {b[AW-1:11], 11'd0}; m_en = 1; m_ext = ext;
  endtask

  // full access: address phase, wait out ready, end cycle, check release
  task automatic access(logic [AW-1:0] a, bit io, string req);
    int idx, lowc;
    idx = exp_idx(a, io);
    lowc = 0;
    @(negedge clk);
    ale = 1; ad = a; io_cycle = io;
    #1;
    chk(pcs_n == exp_pcs(idx), req, "select in ale cycle", int'(pcs_n), int'(exp_pcs(idx)));
    if (!ready) lowc++;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      ale = 0; ad = $urandom;
      #1;
      if (ready) break;
      lowc++;
    end
    chk(lowc == exp_wait(idx), req, "ready low cycles", lowc, exp_wait(idx));
    cyc_end = 1;
    #1;
    chk(pcs_n == exp_pcs(idx), "R6", "select held in end cycle", int'(pcs_n), int'(exp_pcs(idx)));
    @(negedge clk);
    cyc_end = 0;
    #1;
    chk(pcs_n == 7'h7F, "R6", "release after end", int'(pcs_n), 'h7F);
  endtask

  initial begin
    #(CLK * 190000);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    #1;
    chk(pcs_n == 7'h7F, "R1", "reset pcs_n", int'(pcs_n), 'h7F);
    chk(ready == 1, "R1", "reset ready", int'(ready), 1);
    chk(pcs_float == 0, "R1", "reset float", int'(pcs_float), 0);
    rst_n = 1;
    // R1: no decode before configuration (reset base 0, address 0 region)
    access(20'h00000, 1, "R1");
    access(20'h00500, 1, "R1");

    // R4: low bits of written base dropped
    write_cfg(20'h127FF, 0);
    access(20'h12000, 1, "R4");
    access(20'h12610, 1, "R4");
    // R2/R3 directed: every slot
    for (int n = 0; n < 8; n++) access({9'h024, n[2:0], 8'h3C}, 1, (n == 4 || n == 7) ? "R3" : "R2");
    access(20'h12800, 1, "R3");
    access(20'h11FFF, 1, "R3");
    // R5: memory cycle
    access(20'h12500, 0, "R5");
    // R7 short wait, R8 long wait on/off
    access(20'h12600, 1, "R7");
    access(20'h12200, 1, "R8");
    write_cfg(20'h12000, 1);
    access(20'h12300, 1, "R8");
    access(20'h12000, 1, "R8");

    // R9: hold masks, ale ignored, select returns
    @(negedge clk);
    ale = 1; ad = 20'h12500; io_cycle = 1;
    @(negedge clk);
    ale = 1; ad = 20'h12100; hold = 1;
    #1;
    chk(pcs_n == 7'h7F, "R9", "hold forces high", int'(pcs_n), 'h7F);
    chk(pcs_float == 1, "R9", "hold float", int'(pcs_float), 1);
    @(negedge clk);
    ale = 0; hold = 0;
    #1;
    chk(pcs_n == exp_pcs(5), "R9", "select back after hold", int'(pcs_n), int'(exp_pcs(5)));
    for (int k = 0; k < 60 && !ready; k++) begin @(negedge clk); #1; end
    cyc_end = 1;
    @(negedge clk);
    cyc_end = 0;
    #1;
    chk(pcs_n == 7'h7F, "R9", "end after hold", int'(pcs_n), 'h7F);

    // R10: end of one access together with next address phase
    write_cfg(20'h12000, 0);
    @(negedge clk);
    ale = 1; ad = 20'h12100; io_cycle = 1;
    @(negedge clk);
    ale = 1; ad = 20'h12600; cyc_end = 1;
    #1;
    chk(pcs_n == exp_pcs(6), "R10", "new select wins", int'(pcs_n), int'(exp_pcs(6)));
    chk(ready == 0, "R10", "new wait starts", int'(ready), 0);
    begin
      int lowc;
      lowc = 1;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        ale = 0; cyc_end = 0;
        #1;
        if (ready) break;
        lowc++;
      end
      chk(lowc == cdiv(SHORT_NS, CLK), "R10", "reloaded wait", lowc, cdiv(SHORT_NS, CLK));
      chk(pcs_n == exp_pcs(6), "R10", "select kept", int'(pcs_n), int'(exp_pcs(6)));
      cyc_end = 1;
      @(negedge clk);
      cyc_end = 0;
    end

    // random mix
    for (int r = 0; r < 120; r++) begin
      logic [AW-1:0] a;
      if (($urandom % 16) == 0) write_cfg($urandom, $urandom % 2);
      if ($urandom % 2) a = {m_base[AW-1:11], 11'($urandom)};
      else              a = AW'($urandom);
      access(a, ($urandom % 5) != 0, "R2");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule